// File: doc/BRIEF.md
# Dual-Word Programmable Down-Counter Divider

This block divides its clock by a programmable ratio. An 8-bit down counter
runs from a reload value to zero. A registered terminal-count pulse marks each
zero, so one pulse is produced per division period. The reload value comes
from one of two program words. Each word is kept in its own level-sensitive
holding register, and each register has its own load enable. A word-select
input picks the register that feeds the counter at each reload. Two division
ratios can therefore be prepared ahead of time and swapped at a wrap
boundary. Either word can also be rewritten while a period is in progress
without disturbing that period.

A clock-enable input freezes the counter and the output. An asynchronous
active-low reset clears the counter, sets both program registers to all ones
and drives the terminal-count output high. Reset deassertion is expected to
be synchronous to the clock. A program value of zero gives an undefined
ratio; the design leaves the counter parked at zero in that case.

Top module: `dual_word_divider`

## Requirements
- R1: While a load enable is high, its program register follows its program input. While the load enable is low, the register keeps its value and ignores changes on the input.
- R2: With sel_b at 0, the counter reloads from register A. With sel_b at 1, it reloads from register B.
- R3: A program word is read as an unsigned number with bit 7 as the MSB. For a nonzero value N, tc_out pulses every N+1 enabled clocks: 1 gives 2, 11 gives 12, 253 gives 254, 254 gives 255 and 255 gives 256.
- R4: tc_out is a registered output. It is high for exactly one clock in each period, in the cycle during which the counter holds zero.
- R5: While rst_n is low, the counter is 0, both program registers are 0xFF and tc_out is 1. This holds even if a load enable is high. The counter reloads on the first edge after release, so the first tc_out pulse follows 256 clocks later if no word has been loaded.
- R6: While cnt_en is 0, rising edges change neither the counter nor tc_out. A tc_out that is high stays high and a tc_out that is low stays low.
- R7: Changing a program register or sel_b during a period does not change that period's length. The change takes effect at the next reload, provided it is in place before the reload edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low master reset |
| word_a_in | input | 8 | Program value for register A |
| word_b_in | input | 8 | Program value for register B |
| load_a | input | 1 | Transparent-load enable of register A, active high |
| load_b | input | 1 | Transparent-load enable of register B, active high |
| sel_b | input | 1 | Reload source: 0 selects A, 1 selects B |
| cnt_en | input | 1 | Clock enable, active high |
| tc_out | output | 1 | Registered terminal-count pulse |

## Verification
The bench measures the distance between pulses at both ends of the ratio range, 2 and 256. An off-by-one in the reload or the zero detection would show there as a period one clock too short or too long. It changes sel_b and rewrites a word both just after a reload and just before one. A design that fed the multiplexer straight into the live count would therefore shorten or stretch the period in progress, and a design that sampled the word one edge late would miss the swap. Freezing with cnt_en while tc_out is low and again while it is high exposes a design that lets the pulse decay or keeps counting. A reset after reprogramming must return the ratio to 256.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
  localparam int unsigned CNT_W = 8;
  typedef logic [CNT_W-1:0] word_t;
  localparam word_t WORD_RESET = '1;
  localparam word_t WORD_ZERO  = '0;
endpackage

// File: rtl/dwd_word_latch.sv
module dwd_word_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_VAL = '1;

  always_latch begin
    if (!rst_n) begin
      q = RST_VAL;
    end else if (load) begin
      q = d;
    end
  end

  // R1
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load) && $past(rst_n)) |-> $stable(q));
endmodule

// File: rtl/dwd_reload_mux.sv
module dwd_reload_mux #(
  parameter int unsigned W = 8
) (
  input  logic         sel_b,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  output logic [W-1:0] reload
);
  always_comb begin
    reload = sel_b ? word_b : word_a;
  end
endmodule

// File: rtl/dwd_down_counter.sv
module dwd_down_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic         tc
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         tc_q, tc_d;

  always_comb begin
    cnt_d = cnt_q;
    tc_d  = tc_q;
    if (en) begin
      if (cnt_q == ZERO) begin
        cnt_d = reload;
      end else begin
        cnt_d = cnt_q - ONE;
      end
      tc_d = (cnt_d == ZERO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      tc_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

  assign tc = tc_q;

  // R4
  tc_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q == (cnt_q == ZERO));

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && $stable(tc_q)));

  // R2
  reload_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == ZERO) |=> (cnt_q == $past(reload)));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && en && reload != ZERO) |=> !tc_q);
endmodule

// File: rtl/dual_word_divider.sv
module dual_word_divider
  import dwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] word_a_in,
  input  logic [CNT_W-1:0] word_b_in,
  input  logic             load_a,
  input  logic             load_b,
  input  logic             sel_b,
  input  logic             cnt_en,
  output logic             tc_out
);
  word_t held_a, held_b, reload_val;

  dwd_word_latch #(.W(CNT_W)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .load(load_a), .d(word_a_in), .q(held_a)
  );

  dwd_word_latch #(.W(CNT_W)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .load(load_b), .d(word_b_in), .q(held_b)
  );

  dwd_reload_mux #(.W(CNT_W)) u_mux (
    .sel_b(sel_b), .word_a(held_a), .word_b(held_b), .reload(reload_val)
  );

  dwd_down_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .reload(reload_val), .tc(tc_out)
  );

  // R5
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (held_a == WORD_RESET && held_b == WORD_RESET);
    end
  end
endmodule

// File: tb/tb_dual_word_divider.sv
module tb_dual_word_divider;
  localparam int CLK_P = 10;
  localparam int NVEC = 7;
  localparam int VEC_WORD [NVEC] = '{1, 2, 3, 11, 253, 254, 255};
  localparam int VEC_DIV  [NVEC] = '{2, 3, 4, 12, 254, 255, 256};

  logic clk = 1'b0;
  logic rst_n, load_a, load_b, sel_b, cnt_en;
  logic [7:0] word_a, word_b;
  logic tc;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_word_divider dut (
    .clk(clk), .rst_n(rst_n), .word_a_in(word_a), .word_b_in(word_b),
    .load_a(load_a), .load_b(load_b), .sel_b(sel_b), .cnt_en(cnt_en),
    .tc_out(tc)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wait_tc();
    while (!tc) @(negedge clk);
  endtask

  // counts negedges from now until tc is seen high
  task automatic run_period(inout int n);
    do begin
      @(negedge clk);
      n++;
    end while (!tc && n < 700);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; load_a = 1'b0; load_b = 1'b0; sel_b = 1'b0; cnt_en = 1'b1;
    word_a = 8'hFF; word_b = 8'hFF;
    repeat (2) @(negedge clk);
    // R5: loading during reset has no effect
    load_a = 1'b1; word_a = 8'h05;
    @(negedge clk);
    check("R5 tc high in reset", int'(tc), 1);
    load_a = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0; run_period(n);
    check("R5 first period after reset", n, 256);
    @(negedge clk);
    check("R4 pulse one cycle", int'(tc), 0);

    // R3 vector table
    for (int i = 0; i < NVEC; i++) begin
      word_a = 8'(VEC_WORD[i]); load_a = 1'b1;
      @(negedge clk);
      load_a = 1'b0; word_a = 8'h00;  // R1 ignored while load low
      wait_tc();
      n = 0; run_period(n);
      check("R3 divide ratio", n, VEC_DIV[i]);
      @(negedge clk);
      check("R4 pulse one cycle", int'(tc), 0);
    end

    // R2 / R7 select swapping
    word_a = 8'd3; word_b = 8'd6; load_a = 1'b1; load_b = 1'b1;
    @(negedge clk);
    load_a = 1'b0; load_b = 1'b0; word_b = 8'hAA;
    wait_tc();
    n = 0; run_period(n);
    check("R2 sel low uses A", n, 4);
    n = 0; @(negedge clk); n++;
    sel_b = 1'b1;
    run_period(n);
    check("R7 sel change mid-period", n, 4);
    n = 0; run_period(n);
    check("R2 sel high uses B (R1 B held)", n, 7);
    sel_b = 1'b0;  // before the reload edge
    n = 0; run_period(n);
    check("R7 sel before reload edge", n, 4);

    // R1 / R7 transparent reprogramming mid-period
    n = 0; @(negedge clk); n++;
    load_a = 1'b1; word_a = 8'd20;
    @(negedge clk); n++;
    word_a = 8'd9;
    @(negedge clk); n++;
    load_a = 1'b0; word_a = 8'h33;
    run_period(n);
    check("R7 reprogram mid-period", n, 4);
    n = 0; run_period(n);
    check("R1 last transparent value", n, 10);

    // R6 freeze while tc low
    n = 0;
    repeat (2) begin @(negedge clk); n++; end
    cnt_en = 1'b0;
    repeat (6) begin
      @(negedge clk); n++;
      check("R6 tc held low", int'(tc), 0);
    end
    cnt_en = 1'b1;
    run_period(n);
    check("R6 period stretched by hold", n, 16);
    // R6 freeze while tc high
    cnt_en = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R6 tc held high", int'(tc), 1);
    end
    cnt_en = 1'b1;
    n = 0; run_period(n);
    check("R6 resume after hold", n, 10);

    // R5 reset after reprogramming
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R5 tc forced high", int'(tc), 1);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0; run_period(n);
    check("R5 registers back to all ones", n, 256);

    finish_run();
  end
endmodule